// File: doc/BRIEF.md
# Segmentation DMA Burst Throttle

This block sits beside a transmit DMA engine that fills an on-chip packet buffer while large TCP payloads are being segmented. It keeps its own count of free bytes in that buffer. A granted read burst lowers the count, and drain pulses from the transmit side raise it again. The block decides on which cycle the engine may issue its next read burst and how many bytes that burst asks for.

A software-set pad is kept back from the free space so that header insertion always has room. A software-set minimum burst size stops the engine from issuing a string of tiny reads whenever a little space frees up. The minimum is waived for the last piece of a descriptor that is smaller than it. Both settings sit in one 32-bit configuration word. A sticky flag reports a setting that could starve the engine.

A descriptor is handed over as a byte count. The block then issues one request at a time and holds each request until it is granted. When the count reaches zero it pulses a done signal and waits for the next descriptor.

Top module: `seg_burst_throttle`

## Requirements
- R1: After reset the configuration word reads 0x01000400 (pad 256 bytes, minimum 1024 bytes), the free count equals the buffer size, no request is raised and the error flag is low.
- R2: The configuration word carries the pad byte count in bits 31:16 and the minimum burst byte count in bits 15:0. Both fields are written together by `cfg_we` and read back on `cfg_rdata` from the next cycle on.
- R3: Usable space is the free count minus the pad, or zero when the free count does not exceed the pad. A request asks for the smallest of the unfetched bytes, the usable space and the maximum burst length (256 by default), so a burst never lands in the pad.
- R4: While the unfetched byte count is at least the minimum, no request is raised unless the usable space is at least the minimum.
- R5: While the unfetched byte count is below the minimum, the minimum check is skipped, and a request is raised once the usable space holds all of the remaining bytes.
- R6: At most one request is outstanding. `burst_req` stays high with `burst_len` unchanged until `burst_gnt` is sampled high, and no zero-length request is ever made.
- R7: On a grant the free count drops by the granted length. On a drain pulse it rises by `drain_bytes`. Both can happen in the same cycle, and the result saturates at the buffer size.
- R8: The cycle after the grant that fetches the last unfetched byte, `desc_done` is high for exactly one cycle. No further request is raised until a new descriptor with a nonzero byte count is accepted.
- R9: `cfg_err` goes high one cycle after the buffer size is no longer greater than minimum + pad + 80. It then stays high until reset, even if the configuration is corrected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word: pad in 31:16, minimum in 15:0 |
| cfg_rdata | output | 32 | Current configuration word |
| desc_valid | input | 1 | New descriptor offered; accepted only when idle |
| desc_bytes | input | LEN_W | Unfetched bytes of the offered descriptor |
| burst_req | output | 1 | Read burst request |
| burst_len | output | LEN_W | Bytes asked for by the request |
| burst_gnt | input | 1 | Grant of the outstanding request |
| drain_pulse | input | 1 | Bytes left the packet buffer this cycle |
| drain_bytes | input | LEN_W | Byte count of the drain |
| free_bytes | output | FREE_W | Current free byte count of the packet buffer |
| desc_done | output | 1 | One-cycle pulse when a descriptor is fully fetched |
| cfg_err | output | 1 | Sticky flag for an illegal pad/minimum setting |

## Verification
The hardest situation to reach is a stall in which the usable space sits just below the minimum, or just below a small tail, while the buffer is partly drained. It only arises after a run of grants has used up the free space. The stimulus gets there with random descriptor sizes and random legal pad and minimum settings. It grants every request and drains only when a bench model of the free count says no request is due, so each stall is met and then released by drains of random size. Grants that coincide with drains and a drain large enough to hit the saturation limit are forced as directed cases.

// File: rtl/seg_burst_throttle.sv
module seg_burst_throttle #(
  parameter int BUF_BYTES = 4096,
  parameter int MAX_BURST = 256,
  parameter int HDR_SLACK = 80,
  parameter int LEN_W     = 16,
  parameter int FREE_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              desc_valid,
  input  logic [LEN_W-1:0]  desc_bytes,
  output logic              burst_req,
  output logic [LEN_W-1:0]  burst_len,
  input  logic              burst_gnt,
  input  logic              drain_pulse,
  input  logic [LEN_W-1:0]  drain_bytes,
  output logic [FREE_W-1:0] free_bytes,
  output logic              desc_done,
  output logic              cfg_err
);
  localparam int AW = ((FREE_W > LEN_W) ? FREE_W : LEN_W) + 2;
  localparam logic [AW-1:0] BUF_X = AW'(BUF_BYTES);
  localparam logic [AW-1:0] MAX_X = AW'(MAX_BURST);

  logic [15:0]       pad_q, min_q;
  logic [FREE_W-1:0] free_q;
  logic [LEN_W-1:0]  rem_q, len_q;
  logic              active_q, req_q, done_q, err_q;

  logic [AW-1:0] free_x, pad_x, min_x, rem_x, usable, lim, want, free_sum, free_d;
  logic          room, can_issue, fire, bad_cfg;

  assign cfg_rdata  = {pad_q, min_q};
  assign burst_req  = req_q;
  assign burst_len  = len_q;
  assign free_bytes = free_q;
  assign desc_done  = done_q;
  assign cfg_err    = err_q;

  assign free_x = AW'(free_q);
  assign pad_x  = AW'(pad_q);
  assign min_x  = AW'(min_q);
  assign rem_x  = AW'(rem_q);

  assign usable    = (free_x > pad_x) ? free_x - pad_x : '0;
  assign lim       = (rem_x < usable) ? rem_x : usable;
  assign want      = (lim < MAX_X) ? lim : MAX_X;
  assign room      = (rem_x < min_x) ? (usable >= rem_x) : (usable >= min_x);
  assign can_issue = active_q && !req_q && (usable != '0) && room;
  assign fire      = req_q && burst_gnt;
  assign bad_cfg   = BUF_X <= (min_x + pad_x + AW'(HDR_SLACK));

  assign free_sum = free_x - (fire ? AW'(len_q) : '0) + (drain_pulse ? AW'(drain_bytes) : '0);
  assign free_d   = (free_sum > BUF_X) ? BUF_X : free_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pad_q    <= 16'h0100;
      min_q    <= 16'h0400;
      free_q   <= FREE_W'(BUF_BYTES);
      rem_q    <= '0;
      len_q    <= '0;
      active_q <= 1'b0;
      req_q    <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= err_q | bad_cfg;
      free_q <= FREE_W'(free_d);
      if (cfg_we) begin
        pad_q <= cfg_wdata[31:16];
        min_q <= cfg_wdata[15:0];
      end
      if (fire) begin
        req_q <= 1'b0;
        rem_q <= rem_q - len_q;
        if (rem_q == len_q) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end else if (can_issue) begin
        req_q <= 1'b1;
        len_q <= LEN_W'(want);
      end else if (!active_q && desc_valid && desc_bytes != '0) begin
        active_q <= 1'b1;
        rem_q    <= desc_bytes;
      end
    end
  end
endmodule

// File: rtl/seg_burst_throttle_chk.sv
module seg_burst_throttle_chk #(
  parameter int BUF_BYTES = 4096,
  parameter int MAX_BURST = 256,
  parameter int LEN_W     = 16,
  parameter int FREE_W    = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              burst_req,
  input logic [LEN_W-1:0]  burst_len,
  input logic              burst_gnt,
  input logic [FREE_W-1:0] free_bytes,
  input logic [15:0]       pad_q,
  input logic              desc_done,
  input logic              cfg_err
);
  localparam int AW = ((FREE_W > LEN_W) ? FREE_W : LEN_W) + 2;

  assert_len_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |-> (AW'(burst_len) <= AW'(MAX_BURST)));

  assert_pad_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_req) |-> (AW'(burst_len) + AW'($past(pad_q)) <= AW'(free_bytes)));

  assert_nonzero_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |-> (burst_len != '0));

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_req && !burst_gnt) |=> (burst_req && $stable(burst_len)));

  assert_free_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    AW'(free_bytes) <= AW'(BUF_BYTES));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |=> !desc_done);

  assert_done_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |-> !burst_req);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

bind seg_burst_throttle seg_burst_throttle_chk #(
  .BUF_BYTES(BUF_BYTES), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W), .FREE_W(FREE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .burst_req(burst_req), .burst_len(burst_len),
  .burst_gnt(burst_gnt), .free_bytes(free_bytes), .pad_q(pad_q),
  .desc_done(desc_done), .cfg_err(cfg_err)
);

// File: tb/seg_burst_throttle_test.sv
module seg_burst_throttle_test;
  localparam int BUF = 4096;
  localparam int MAXB = 256;
  localparam int LW = 16;
  localparam int FW = $clog2(BUF + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, desc_valid = 1'b0, burst_gnt = 1'b0, drain_pulse = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [LW-1:0] desc_bytes = '0, drain_bytes = '0, burst_len;
  logic [FW-1:0] free_bytes;
  logic burst_req, desc_done, cfg_err;

  int n_chk = 0, n_fail = 0;
  int m_free = BUF, m_pad = 256, m_min = 1024, m_rem = 0;
  int unsigned seed_dummy;

  always #5 clk = ~clk;

  seg_burst_throttle uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .desc_valid(desc_valid), .desc_bytes(desc_bytes), .burst_req(burst_req),
    .burst_len(burst_len), .burst_gnt(burst_gnt), .drain_pulse(drain_pulse),
    .drain_bytes(drain_bytes), .free_bytes(free_bytes), .desc_done(desc_done),
    .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int usable_of(int f, int p);
    return (f > p) ? f - p : 0;
  endfunction

  function automatic bit exp_elig(int f, int p, int mn, int r);
    int u = usable_of(f, p);
    if (r == 0 || u == 0) return 1'b0;
    if (r < mn) return u >= r;
    return u >= mn;
  endfunction

  function automatic int exp_len(int f, int p, int r);
    int u = usable_of(f, p);
    int l = (r < u) ? r : u;
    return (l < MAXB) ? l : MAXB;
  endfunction

  function automatic int sat(int v);
    return (v > BUF) ? BUF : v;
  endfunction

  task automatic write_cfg(input int pad, input int mn);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = {pad[15:0], mn[15:0]};
    @(negedge clk);
    cfg_we = 1'b0;
    m_pad = pad; m_min = mn;
    chk(cfg_rdata == {pad[15:0], mn[15:0]}, "R2 cfg readback", cfg_rdata, {pad[15:0], mn[15:0]});
  endtask

  task automatic drain(input int amt);
    @(negedge clk);
    drain_pulse = 1'b1; drain_bytes = LW'(amt);
    @(negedge clk);
    drain_pulse = 1'b0;
    m_free = sat(m_free + amt);
    chk(free_bytes == FW'(m_free), "R7 drain", free_bytes, m_free);
  endtask

  task automatic run_desc(input int n);
    int guard = 0;
    @(negedge clk);
    desc_valid = 1'b1; desc_bytes = LW'(n);
    @(negedge clk);
    desc_valid = 1'b0;
    m_rem = n;
    while (m_rem > 0 && guard < 400) begin
      bit got = 1'b0;
      guard++;
      for (int i = 0; i < 4 && !got; i++) begin
        @(negedge clk);
        got = burst_req;
      end
      if (got) begin
        int el = exp_elig(m_free, m_pad, m_min, m_rem);
        int ln = exp_len(m_free, m_pad, m_rem);
        int d = $urandom % 3;
        int dr = 0;
        logic [LW-1:0] held = burst_len;
        chk(el == 1, (m_rem < m_min) ? "R5 tail request allowed" : "R4 request allowed", 1, el);
        chk(burst_len == LW'(ln), "R3 burst length", burst_len, ln);
        for (int i = 0; i < d; i++) begin
          @(negedge clk);
          chk(burst_req && burst_len == held, "R6 request held", burst_len, held);
        end
        if ($urandom % 10 < 3) dr = 1 + $urandom % 700;
        burst_gnt = 1'b1;
        drain_pulse = (dr != 0); drain_bytes = LW'(dr);
        @(negedge clk);
        burst_gnt = 1'b0; drain_pulse = 1'b0;
        m_free = sat(m_free - ln + dr);
        m_rem -= ln;
        chk(free_bytes == FW'(m_free), "R7 grant accounting", free_bytes, m_free);
        chk(desc_done == (m_rem == 0), "R8 done timing", desc_done, m_rem == 0);
      end else begin
        chk(!exp_elig(m_free, m_pad, m_min, m_rem),
            (m_rem < m_min) ? "R5 tail held" : "R4 held below minimum", 0, 1);
        drain(1 + $urandom % 600);
      end
    end
    chk(m_rem == 0, "R8 descriptor finished", m_rem, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!burst_req && !desc_done, "R8 idle after done", burst_req, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_rdata == 32'h01000400, "R1 reset cfg", cfg_rdata, 32'h01000400);
    chk(free_bytes == FW'(BUF), "R1 reset free", free_bytes, BUF);
    chk(!burst_req && !cfg_err && !desc_done, "R1 reset outputs", burst_req, 0);

    run_desc(300);
    drain(4000);
    chk(free_bytes == FW'(BUF), "R7 saturation", free_bytes, BUF);

    @(negedge clk);
    desc_valid = 1'b1; desc_bytes = '0;
    @(negedge clk);
    desc_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!burst_req, "R8 zero descriptor ignored", burst_req, 0);

    for (int k = 0; k < 40; k++) begin
      if (k % 8 == 4) write_cfg($urandom % 512, $urandom % 1500);
      run_desc(1 + $urandom % 3000);
    end
    chk(!cfg_err, "R9 legal configs keep flag low", cfg_err, 0);

    write_cfg(16'h0100, 16'h0F00);
    @(negedge clk);
    chk(cfg_err, "R9 illegal config flagged", cfg_err, 1);
    write_cfg(16'h0100, 16'h0400);
    repeat (2) @(negedge clk);
    chk(cfg_err, "R9 flag sticky", cfg_err, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule